// File: doc/BRIEF.md
# Vectored Interrupt Entry Controller

This block sits beside the instruction decoder of a small 8-bit microcontroller core. It decides when the core leaves its normal instruction flow and which address it jumps to. On reset it forces the program counter load to address zero. When one of four interrupt sources is accepted, it produces the fixed entry vector for that source and sends a one-cycle acknowledge back to that source's request flag. The four sources are two external pins, a timer overflow and an RC-oscillation converter event.

The block also holds a four-level return stack of program-counter values. Subroutine calls and accepted interrupts both push onto this stack, and returns pop from it. Software cannot read or write the stack except through calls and returns. An interrupt is accepted only while the stack has a free level. A request that arrives while the stack is full stays pending and is taken once a return frees a level.

All outputs are registered. Every decision made from the inputs of one cycle appears on the outputs in the following cycle. The logic that owns the request flags and the global enable clears the acknowledged flag and the global enable on the clock edge that follows the acknowledge.

Top module: `irq_vector_ctl`

## Requirements
- R1: At every clock edge with `rst` high, the outputs become `vec_valid_o`=1, `vec_addr_o`=0x000, `ack_o`=0, `ret_valid_o`=0 and `ret_addr_o`=0, and the return stack is emptied.
- R2: An accepted source k (bit k of the request, enable and acknowledge vectors) loads the vector 0x004 for k=0, 0x008 for k=1, 0x00C for k=2 and 0x010 for k=3. In the next cycle `vec_valid_o`=1, `vec_addr_o` holds that vector and `ack_o` is one-hot on bit k.
- R3: Source k is accepted in a cycle only if all of the following hold in that cycle: `req_i[k]`, `en_i[k]` and `gie_i` are all 1; the stack holds fewer than 4 entries; `call_i` and `ret_i` are both 0; and `ack_o` is 0. When no source is accepted, the next cycle shows `vec_valid_o`=0 and `ack_o`=0.
- R4: When several sources qualify in the same cycle, the one with the lowest index (lowest vector address) is accepted.
- R5: `ack_o` is high for exactly one cycle per acceptance, and never has more than one bit set. No source is accepted in a cycle in which `ack_o` is nonzero, so a flag that is still set is not taken twice.
- R6: A call, or an accepted interrupt, pushes that cycle's `pc_i`. A return in a cycle gives `ret_valid_o`=1 for one cycle in the next cycle, with `ret_addr_o` equal to the most recently pushed entry that has not yet been popped (last in, first out). `ret_addr_o` holds its value between returns.
- R7: A call made while 4 entries are held overwrites the oldest entry in circular order. The level stays at 4, so the next four returns give the newest four addresses.
- R8: A return while the stack is empty still steps the stack pointer back in circular order. It returns the entry stored in that slot, and the level stays at 0.
- R9: A qualifying request that arrives while the stack is full is not accepted, and it stays pending. It is accepted in the first cycle after a return that satisfies R3.
- R10: When `call_i` and `ret_i` are high in the same cycle, only the return is performed, and nothing is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 4 | Latched request flag per source |
| en_i | input | 4 | Per-source interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| call_i | input | 1 | Subroutine call strobe from the decoder |
| ret_i | input | 1 | Return strobe from the decoder |
| pc_i | input | 11 | Current program counter, the value pushed on a call or on an acceptance |
| vec_valid_o | output | 1 | Program-counter load request (reset or interrupt entry) |
| vec_addr_o | output | 11 | Program-counter load value |
| ack_o | output | 4 | One-cycle acknowledge, one bit per source |
| ret_valid_o | output | 1 | A popped return address is presented |
| ret_addr_o | output | 11 | Popped return address |

## Verification
The bound checker watches the acceptance rules on every cycle. It checks that each acknowledge was qualified by the request, the enable and the global enable, that no call or return was in flight when it was taken, and that the stack was not full. It also checks that a lower-numbered qualifying source was never passed over, that each acknowledge carries its own vector, and that acknowledges are one-hot single pulses. What the assertions cannot see is the content of the stack. Last-in-first-out order, the circular overwrite on a full call, the wrapping pop from an empty stack, a call and a return in the same cycle, and a blocked request resuming after a return are shown only by the bench's scenarios against its own model of the stack.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  // Default sizes for the interrupt entry controller.
  parameter int PC_W       = 11;  // 2048-word program space
  parameter int NSRC       = 4;   // interrupt sources
  parameter int STK_DEPTH  = 4;   // return stack levels
  parameter int VEC_STRIDE = 4;   // words between consecutive vectors

  // Entry vector of source idx: the first vector sits one stride above zero.
  function automatic int vec_word(input int idx);
    return (idx + 1) * VEC_STRIDE;
  endfunction
endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // seen[k] is set when any candidate below index k is present
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_chain
    assign grant_o[k]  = cand_i[k] & ~seen[k];
    assign seen[k+1]   = seen[k] | cand_i[k];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (cand_i[k]) idx_o = IW'(k);
    end
  end
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 11,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         full_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] ptr_q;
  logic [LW-1:0] lvl_q;
  logic [AW-1:0] ptr_inc, ptr_dec;
  logic          do_push;

  // A pop wins over a push in the same cycle.
  assign do_push = push_i & ~pop_i;
  assign ptr_inc = (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  assign ptr_dec = (ptr_q == '0) ? AW'(DEPTH - 1) : ptr_q - 1'b1;
  assign full_o  = (lvl_q == LW'(DEPTH));

  // Storage: single write port, registered read, no reset.
  always_ff @(posedge clk) begin
    if (do_push) mem[ptr_q] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o <= '0;
    end else if (pop_i) begin
      dout_o <= mem[ptr_dec];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      lvl_q <= '0;
    end else if (pop_i) begin
      ptr_q <= ptr_dec;
      if (lvl_q != '0) lvl_q <= lvl_q - 1'b1;
    end else if (do_push) begin
      ptr_q <= ptr_inc;
      if (!full_o) lvl_q <= lvl_q + 1'b1;
    end
  end
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
  import irq_vec_pkg::*;
#(
  parameter int PC_W      = irq_vec_pkg::PC_W,
  parameter int NSRC      = irq_vec_pkg::NSRC,
  parameter int STK_DEPTH = irq_vec_pkg::STK_DEPTH,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            gie_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            vec_valid_o,
  output logic [PC_W-1:0] vec_addr_o,
  output logic [NSRC-1:0] ack_o,
  output logic            ret_valid_o,
  output logic [PC_W-1:0] ret_addr_o
);
  logic [NSRC-1:0] cand, grant;
  logic [IW-1:0]   win_idx;
  logic            any_cand;
  logic            stk_full;
  logic            take;
  logic [PC_W-1:0] win_vec;

  assign cand = req_i & en_i & {NSRC{gie_i}};

  irq_prio_sel #(.N(NSRC)) u_sel (
    .cand_i  (cand),
    .grant_o (grant),
    .idx_o   (win_idx),
    .any_o   (any_cand)
  );

  // Accept only between instructions, with room on the stack, and not
  // while the previous acknowledge is still clearing its flag.
  assign take    = any_cand & ~stk_full & ~call_i & ~ret_i & ~(|ack_o);
  assign win_vec = PC_W'(vec_word(int'(win_idx)));

  irq_ret_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stk (
    .clk    (clk),
    .rst    (rst),
    .push_i (call_i | take),
    .pop_i  (ret_i),
    .din_i  (pc_i),
    .dout_o (ret_addr_o),
    .full_o (stk_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid_o <= 1'b1;
      vec_addr_o  <= '0;
      ack_o       <= '0;
      ret_valid_o <= 1'b0;
    end else begin
      vec_valid_o <= take;
      vec_addr_o  <= take ? win_vec : '0;
      ack_o       <= take ? grant : '0;
      ret_valid_o <= ret_i;
    end
  end
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk #(
  parameter int PC_W = 11,
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] req_i,
  input logic [NSRC-1:0] en_i,
  input logic            gie_i,
  input logic            call_i,
  input logic            ret_i,
  input logic            vec_valid_o,
  input logic [PC_W-1:0] vec_addr_o,
  input logic [NSRC-1:0] ack_o,
  input logic            ret_valid_o,
  input logic            stk_full
);
  AST_RESET_VEC: assert property (@(posedge clk)
    rst |=> (vec_valid_o && vec_addr_o == '0 && ack_o == '0 && !ret_valid_o)); // R1

  for (genvar k = 0; k < NSRC; k++) begin : g_vec
    AST_VEC_ADDR: assert property (@(posedge clk) disable iff (rst)
      ack_o[k] |-> (vec_valid_o && vec_addr_o == PC_W'(4 * (k + 1)))); // R2
  end

  AST_ACCEPT_QUAL: assert property (@(posedge clk) disable iff (rst)
    (|ack_o) |-> ($past(gie_i) && ((ack_o & $past(req_i & en_i)) != '0)
                  && !$past(call_i) && !$past(ret_i))); // R3

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
    (|ack_o) |-> (((ack_o - 1'b1) & $past(req_i & en_i)) == '0)); // R4

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_o)); // R5

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    (|ack_o) |=> (ack_o == '0)); // R5

  AST_RET_STROBE: assert property (@(posedge clk) disable iff (rst)
    ret_i |=> ret_valid_o); // R6

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (|ack_o) |-> !$past(stk_full)); // R9
endmodule

bind irq_vector_ctl irq_vector_chk #(.PC_W(PC_W), .NSRC(NSRC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_i       (req_i),
  .en_i        (en_i),
  .gie_i       (gie_i),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .vec_valid_o (vec_valid_o),
  .vec_addr_o  (vec_addr_o),
  .ack_o       (ack_o),
  .ret_valid_o (ret_valid_o),
  .stk_full    (stk_full)
);

// File: tb/sim_irq_vector_ctl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  req_i = '0, en_i = '0;
  logic        gie_i = 1'b0, call_i = 1'b0, ret_i = 1'b0;
  logic [10:0] pc_i = '0;
  logic        vec_valid_o, ret_valid_o;
  logic [10:0] vec_addr_o, ret_addr_o;
  logic [3:0]  ack_o;

  irq_vector_ctl u0 (
    .clk(clk), .rst(rst), .req_i(req_i), .en_i(en_i), .gie_i(gie_i),
    .call_i(call_i), .ret_i(ret_i), .pc_i(pc_i),
    .vec_valid_o(vec_valid_o), .vec_addr_o(vec_addr_o), .ack_o(ack_o),
    .ret_valid_o(ret_valid_o), .ret_addr_o(ret_addr_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    int          tgt;
    logic        vv;
    logic [10:0] va;
    logic [3:0]  ack;
    logic        rv;
    logic [10:0] ra;
    string       tag;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 0;

  // bench-side state: flag owner and reference stack
  logic [3:0]  req_s = '0, en_s = '0;
  logic        gie_s = 1'b0, rst_s = 1'b1;
  logic [3:0]  cur_ack = '0;
  logic [10:0] m_mem [4] = '{default: '0};
  int          m_ptr = 0, m_lvl = 0;
  logic [10:0] m_ra = '0;
  string       cur_tag = "R1";

  always @(posedge clk) cyc++;

  // monitor: compare every expected item in the cycle it targets
  always @(posedge clk) begin
    #5;
    while (sb.size() > 0 && sb[0].tgt == cyc) begin
      item_t it;
      it = sb.pop_front();
      n_checks++;
      if (vec_valid_o !== it.vv || vec_addr_o !== it.va || ack_o !== it.ack ||
          ret_valid_o !== it.rv || ret_addr_o !== it.ra) begin
        n_errors++;
        $display("FAIL %s cyc %0d: got vv=%b va=%h ack=%b rv=%b ra=%h exp vv=%b va=%h ack=%b rv=%b ra=%h",
                 it.tag, cyc, vec_valid_o, vec_addr_o, ack_o, ret_valid_o, ret_addr_o,
                 it.vv, it.va, it.ack, it.rv, it.ra);
      end
    end
  end

  // driver: apply one cycle of inputs and queue the expected outcome
  task automatic step(input logic c, input logic r, input logic [10:0] p);
    item_t it;
    logic [3:0] cand;
    logic take;
    @(posedge clk); #2;
    if (cur_ack != 0) begin
      req_s &= ~cur_ack;
      gie_s = 1'b0;
    end
    rst = rst_s; req_i = req_s; en_i = en_s; gie_i = gie_s;
    call_i = c; ret_i = r; pc_i = p;
    it.tgt = cyc + 1; it.tag = cur_tag;
    it.vv = 0; it.va = '0; it.ack = '0; it.rv = 0;
    if (rst_s) begin
      it.vv = 1; m_ptr = 0; m_lvl = 0; m_ra = '0;
    end else begin
      cand = req_s & en_s & {4{gie_s}};
      take = (cand != 0) && (m_lvl < 4) && !c && !r && (cur_ack == 0);
      if (take) begin
        for (int k = 3; k >= 0; k--) if (cand[k]) begin
          it.ack = 4'(1 << k);
          it.va = 11'((k + 1) * 4);
        end
        it.vv = 1;
      end
      if (r) begin
        m_ptr = (m_ptr + 3) % 4;
        m_ra = m_mem[m_ptr];
        it.rv = 1;
        if (m_lvl > 0) m_lvl--;
      end else if (c || take) begin
        m_mem[m_ptr] = p;
        m_ptr = (m_ptr + 1) % 4;
        if (m_lvl < 4) m_lvl++;
      end
    end
    it.ra = m_ra;
    cur_ack = it.ack;
    sb.push_back(it);
  endtask

  initial begin
    en_s = 4'hF;
    // R1: reset state
    cur_tag = "R1";
    for (int i = 0; i < 3; i++) step(0, 0, 11'h7FF);
    rst_s = 0;
    step(0, 0, 0);

    // R2 each source alone, then R6 return to the pushed pc
    for (int s = 0; s < 4; s++) begin
      cur_tag = "R2"; req_s[s] = 1'b1; gie_s = 1'b1;
      step(0, 0, 11'(12'h100 + s));
      cur_tag = "R5"; step(0, 0, 0);
      cur_tag = "R6"; step(0, 1, 0);
      step(0, 0, 0);
    end

    // R4 all pending: taken lowest first, fills the stack
    cur_tag = "R4"; req_s = 4'hF;
    for (int s = 0; s < 4; s++) begin
      gie_s = 1'b1;
      step(0, 0, 11'(12'h200 + s));
      cur_tag = "R5"; step(0, 0, 0);
      cur_tag = "R4";
    end
    cur_tag = "R6";
    for (int i = 0; i < 4; i++) step(0, 1, 0);

    // R3 gating by enable, global enable and a call in flight
    cur_tag = "R3"; en_s = 4'b1011; req_s[2] = 1'b1; gie_s = 1'b1;
    step(0, 0, 11'h111);
    en_s = 4'hF; gie_s = 1'b0;
    step(0, 0, 11'h112);
    gie_s = 1'b1;
    step(1, 0, 11'h113);
    step(0, 0, 11'h114);
    step(0, 0, 0);
    cur_tag = "R6"; step(0, 1, 0); step(0, 1, 0);

    // R9 full stack holds the request until a return frees a level
    cur_tag = "R9";
    for (int i = 0; i < 4; i++) step(1, 0, 11'(12'h300 + i));
    req_s[1] = 1'b1; gie_s = 1'b1;
    step(0, 0, 11'h3A0);
    step(0, 0, 11'h3A1);
    step(0, 1, 11'h3A2);
    step(0, 0, 11'h3A3);
    step(0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 0);

    // R7 overwrite on full call, R8 pop from empty wraps
    cur_tag = "R7";
    for (int i = 0; i < 5; i++) step(1, 0, 11'(12'h400 + i));
    for (int i = 0; i < 4; i++) step(0, 1, 0);
    cur_tag = "R8"; step(0, 1, 0);
    step(0, 0, 0);

    // R10 call with return performs only the return
    cur_tag = "R10";
    step(1, 0, 11'h4F0);
    step(1, 0, 11'h4F1);
    step(1, 1, 11'h500);
    step(0, 1, 0);
    step(0, 0, 0);

    // R1 reset again after activity
    cur_tag = "R1"; rst_s = 1;
    step(0, 0, 0);
    step(0, 0, 0);
    rst_s = 0;
    step(0, 0, 0);
    for (int i = 0; i < 3; i++) @(posedge clk);
    #8;
    if (sb.size() != 0) begin
      n_errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule